// File: doc/BRIEF.md
# Hypercube Dimension-Order Router Node

This block is one router node of a binary hypercube with sixteen nodes, each named by a four-bit address. A node has one bidirectional link per dimension, and the neighbour across dimension k is the node whose address differs only in bit k. It also has a local port through which packets are injected and delivered. Every channel uses a valid/ready handshake. Each output channel, the four links and the local delivery port, ends in a single register.

On every hop the node takes the bitwise difference (XOR) of its own address and the packet's destination. A zero difference means the packet has arrived, and it leaves on the local port. Otherwise the packet leaves on the link of the lowest-numbered differing bit. This fixed ascending order gives each pair of nodes exactly one route.

When several inputs want the same output in one cycle, the input with the lowest index wins. The losers see ready low and keep presenting their packet. Each flit carries a hop counter that grows by one on every link it crosses, so a delivered packet shows the length of its route.

Top module: `hcr_node`

## Requirements
- R1: A packet whose destination equals `node_id` leaves on output 4, the local port, with its hop field unchanged.
- R2: A packet with a nonzero XOR of `node_id` and destination leaves on link output k, where k is the lowest set bit of that XOR. No other output carries it.
- R3: A packet leaving on a link output (0 to 3) has its hop field increased by one. A packet leaving on the local output keeps its hop field.
- R4: When several inputs target the same output, the lowest input index is served first. Link inputs are 0 to 3 and the local injection input is 4, the lowest priority.
- R5: An input that loses arbitration, or whose target output is full and stalled, sees `in_ready` low for that cycle. A held packet is served in a later cycle.
- R6: While an output has valid high and ready low, it keeps valid high and its flit unchanged.
- R7: A packet accepted at a clock edge appears on its output right after that edge. Its destination and payload are unchanged. A flit is 15 bits: destination [14:11], hop count [10:8], payload [7:0]. Channel i uses bits [15*i+14 : 15*i] of the flat bus.
- R8: While reset is low at a clock edge, every output valid is low after that edge.
- R9: A packet injected with hop count 0 and passed node to node reaches its destination. On delivery its hop count equals the number of set bits in source XOR destination, never more than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| node_id | input | 4 | This node's address, held static in operation |
| in_valid | input | 5 | Valid per input channel (0..3 links, 4 local inject) |
| in_flit | input | 75 | Five flits, channel i at bits [15*i+14:15*i] |
| in_ready | output | 5 | Ready per input channel |
| out_valid | output | 5 | Valid per output channel (0..3 links, 4 local deliver) |
| out_ready | input | 5 | Ready per output channel from the receiver |
| out_flit | output | 75 | Five output flits, same layout as `in_flit` |

## Verification
Directed cases compare a single-bit XOR, a top-bit XOR, the worked 0101 to 1011 example and a zero XOR. Together they separate lowest-bit selection from any other pick and separate local delivery from link forwarding. Three inputs competing for one link, and a stalled output with a waiting packet, separate fixed priority and hold-on-stall from lossy or reordered arbitration. Random all-input traffic is checked cycle by cycle against an arbitration model, which exposes wrong grants and missed hop increments. Random source/destination walks relay packets hop by hop through the node with a changing address, checking route length and payload integrity end to end.

// File: rtl/hcr_pkg.sv
// Shared sizes and flit layout for the hypercube router node.
// Assumes a single cube size per build; every module derives widths from here.
package hcr_pkg;
    parameter int unsigned HC_DIM = 4;                    // cube dimensions
    parameter int unsigned PAY_W  = 8;                    // payload bits
    localparam int unsigned HOP_W = $clog2(HC_DIM + 1);   // holds 0..HC_DIM
    localparam int unsigned NPORT = HC_DIM + 1;           // links plus local

    typedef struct packed {
        logic [HC_DIM-1:0] dest;
        logic [HOP_W-1:0]  hops;
        logic [PAY_W-1:0]  payload;
    } flit_t;

    localparam int unsigned FLIT_W = $bits(flit_t);
endpackage

// File: rtl/hcr_route_sel.sv
// Route selector: turns one input's destination into a one-hot output request.
// Picks the lowest differing address bit; no difference requests the local port.
// Assumes node_id is static while traffic flows.
module hcr_route_sel #(
    parameter int unsigned DIM = hcr_pkg::HC_DIM
) (
    input  logic [DIM-1:0] node_id,
    input  logic [DIM-1:0] dest,
    input  logic           valid,
    output logic [DIM:0]   req
);
    logic [DIM-1:0] diff;
    logic           hit;

    // Scan difference bits upward and request the first one found.
    always_comb begin
        diff = node_id ^ dest;
        req  = '0;
        hit  = 1'b0;
        for (int k = 0; k < int'(DIM); k++) begin
            if (valid && diff[k] && !hit) begin
                req[k] = 1'b1;
                hit    = 1'b1;
            end
        end
        if (valid && !hit) begin
            req[DIM] = 1'b1;
        end
    end
endmodule

// File: rtl/hcr_out_port.sv
// Output channel: fixed-priority arbiter plus a one-entry output register.
// Lowest input index wins. A grant happens only when the register is empty
// or draining this cycle. Link variants add one to the hop field.
module hcr_out_port
    import hcr_pkg::*;
#(
    parameter int unsigned NIN     = NPORT,
    parameter bit          IS_LINK = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NIN-1:0]      req,
    input  flit_t [NIN-1:0]     cand,
    output logic [NIN-1:0]      grant,
    input  logic                out_ready,
    output logic                out_valid,
    output flit_t               out_flit
);
    logic  can_load;
    logic  taken;
    flit_t pick;
    flit_t next_flit;

    // The register may take a new flit when empty or being drained.
    always_comb begin
        can_load = !out_valid || out_ready;
    end

    // Fixed priority: first requesting input from index 0 upward.
    always_comb begin
        grant = '0;
        taken = 1'b0;
        if (can_load) begin
            for (int i = 0; i < int'(NIN); i++) begin
                if (req[i] && !taken) begin
                    grant[i] = 1'b1;
                    taken    = 1'b1;
                end
            end
        end
    end

    // Select the granted candidate flit.
    always_comb begin
        pick = '0;
        for (int i = 0; i < int'(NIN); i++) begin
            if (grant[i]) begin
                pick = cand[i];
            end
        end
    end

    generate
        if (IS_LINK) begin : g_link
            // Crossing a link counts one more hop.
            always_comb begin
                next_flit      = pick;
                next_flit.hops = pick.hops + HOP_W'(1);
            end
        end else begin : g_local
            // Local delivery passes the flit through unchanged.
            always_comb begin
                next_flit = pick;
            end
        end
    endgenerate

    // Output register: load on grant, clear when drained with nothing new.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_flit  <= '0;
        end else if (can_load) begin
            out_valid <= taken;
            if (taken) begin
                out_flit <= next_flit;
            end
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_flit)); // R6
    AST_FILL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> out_valid); // R7
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R4
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R8
endmodule

// File: rtl/hcr_node.sv
// Hypercube router node: one route selector per input, one arbitrated
// output register per output. Channels 0..DIM-1 are links (channel k goes to
// the neighbour differing in address bit k); channel DIM is the local port.
// Assumes node_id changes only while the node holds no traffic.
module hcr_node
    import hcr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [HC_DIM-1:0]      node_id,
    input  logic [NPORT-1:0]       in_valid,
    input  logic [NPORT*FLIT_W-1:0] in_flit,
    output logic [NPORT-1:0]       in_ready,
    output logic [NPORT-1:0]       out_valid,
    input  logic [NPORT-1:0]       out_ready,
    output logic [NPORT*FLIT_W-1:0] out_flit
);
    flit_t [NPORT-1:0] in_f;
    flit_t [NPORT-1:0] out_f;
    logic  [NPORT-1:0] req_by_in  [NPORT];
    logic  [NPORT-1:0] req_by_out [NPORT];
    logic  [NPORT-1:0] gnt_by_out [NPORT];

    // Unpack the flat input bus into flits.
    always_comb begin
        in_f = in_flit;
    end

    genvar gi, go;
    generate
        for (gi = 0; gi < int'(NPORT); gi++) begin : g_in
            hcr_route_sel #(.DIM(HC_DIM)) u_sel (
                .node_id (node_id),
                .dest    (in_f[gi].dest),
                .valid   (in_valid[gi]),
                .req     (req_by_in[gi])
            );
        end
    endgenerate

    // Transpose requests so each output sees one bit per input.
    always_comb begin
        for (int o = 0; o < int'(NPORT); o++) begin
            for (int i = 0; i < int'(NPORT); i++) begin
                req_by_out[o][i] = req_by_in[i][o];
            end
        end
    end

    generate
        for (go = 0; go < int'(NPORT); go++) begin : g_out
            hcr_out_port #(
                .NIN     (NPORT),
                .IS_LINK (go < int'(HC_DIM))
            ) u_port (
                .clk       (clk),
                .rst_n     (rst_n),
                .req       (req_by_out[go]),
                .cand      (in_f),
                .grant     (gnt_by_out[go]),
                .out_ready (out_ready[go]),
                .out_valid (out_valid[go]),
                .out_flit  (out_f[go])
            );

            if (go < int'(HC_DIM)) begin : g_chk_link
                AST_LINK_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
                    out_valid[go] |-> out_f[go].dest[go] != node_id[go]); // R2
            end else begin : g_chk_local
                AST_LOCAL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
                    out_valid[go] |-> out_f[go].dest == node_id); // R1
            end
            AST_HOP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[go] |-> out_f[go].hops <= HOP_W'(HC_DIM)); // R9
        end
    endgenerate

    // An input is ready when its requested output granted it.
    always_comb begin
        in_ready = '0;
        for (int i = 0; i < int'(NPORT); i++) begin
            for (int o = 0; o < int'(NPORT); o++) begin
                if (gnt_by_out[o][i]) begin
                    in_ready[i] = 1'b1;
                end
            end
        end
    end

    // Pack output flits onto the flat bus.
    always_comb begin
        out_flit = out_f;
    end
endmodule

// File: tb/hcr_node_tb_top.sv
module hcr_node_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIM = 4;
    localparam int NP  = 5;
    localparam int FW  = 15;
    localparam int PW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIM-1:0]    node_id = '0;
    logic [NP-1:0]     in_valid = '0;
    logic [NP*FW-1:0]  in_flit = '0;
    logic [NP-1:0]     in_ready;
    logic [NP-1:0]     out_valid;
    logic [NP-1:0]     out_ready = '1;
    logic [NP*FW-1:0]  out_flit;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hcr_node dut_i (
        .clk(clk), .rst_n(rst_n), .node_id(node_id),
        .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
    );

    function automatic logic [FW-1:0] mk(input logic [3:0] d, input logic [2:0] h, input logic [7:0] p);
        return {d, h, p};
    endfunction

    function automatic int exp_port(input logic [3:0] node, input logic [3:0] d);
        logic [3:0] x;
        x = node ^ d;
        for (int k = 0; k < DIM; k++) if (x[k]) return k;
        return DIM;
    endfunction

    function automatic logic [FW-1:0] ofl(input int o);
        return out_flit[o*FW +: FW];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input int i, input logic [FW-1:0] f);
        in_valid[i] = 1'b1;
        in_flit[i*FW +: FW] = f;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Relay a packet through the node hop by hop, renaming the node each hop.
    task automatic walk(input logic [3:0] src, input logic [3:0] dst, input logic [7:0] pay);
        logic [3:0] cur;
        int pin;
        int e;
        logic [FW-1:0] fl;
        logic [FW-1:0] got;
        bit done;
        cur = src; pin = DIM; fl = mk(dst, 3'd0, pay); done = 0;
        for (int h = 0; h <= DIM && !done; h++) begin
            @(negedge clk);
            node_id = cur; in_valid = '0; put(pin, fl);
            @(negedge clk);
            in_valid = '0;
            e = exp_port(cur, dst);
            got = ofl(e);
            if (e == DIM) chk(out_valid == NP'(1 << e), "R1", out_valid, 1 << e);
            else          chk(out_valid == NP'(1 << e), "R2", out_valid, 1 << e);
            chk(got[PW-1:0] == pay && got[FW-1 -: 4] == dst, "R7", got, {dst, 3'b0, pay});
            if (e == DIM) begin
                chk(got[10:8] == 3'($countones(src ^ dst)), "R9", got[10:8], $countones(src ^ dst));
                done = 1;
            end else begin
                cur = cur ^ 4'(1 << e); pin = e; fl = got;
            end
        end
        chk(done, "R9", done, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [FW-1:0] f;
        logic [FW-1:0] fl_in [NP];
        logic [NP-1:0] exp_rdy;
        logic [NP-1:0] exp_v;
        logic [FW-1:0] exp_f [NP];
        void'($urandom(32'h1f2e3d4c));

        // R8: outputs empty during reset
        repeat (3) @(negedge clk);
        chk(out_valid == '0, "R8", out_valid, 0);
        rst_n = 1'b1;

        // R2/R3: worked example 0101 -> 1011, lowest differing bit is bit 1
        @(negedge clk); node_id = 4'b0101; put(DIM, mk(4'b1011, 3'd0, 8'h5a));
        @(negedge clk); in_valid = '0;
        chk(out_valid == 5'b00010, "R2", out_valid, 5'b00010);
        f = ofl(1);
        chk(f[10:8] == 3'd1, "R3", f[10:8], 1);

        // R2: only the top bit differs
        @(negedge clk); node_id = 4'b0000; put(DIM, mk(4'b1000, 3'd2, 8'h33));
        @(negedge clk); in_valid = '0;
        chk(out_valid == 5'b01000, "R2", out_valid, 5'b01000);
        f = ofl(3);
        chk(f[10:8] == 3'd3, "R3", f[10:8], 3);

        // R1/R3: arrival delivers locally with the hop field untouched
        @(negedge clk); node_id = 4'b1001; put(2, mk(4'b1001, 3'd2, 8'hc4));
        @(negedge clk); in_valid = '0;
        chk(out_valid == 5'b10000, "R1", out_valid, 5'b10000);
        f = ofl(DIM);
        chk(f == mk(4'b1001, 3'd2, 8'hc4), "R3", f, mk(4'b1001, 3'd2, 8'hc4));

        // R4/R5: three inputs compete for link 0
        @(negedge clk); node_id = 4'b0000;
        put(0, mk(4'b0001, 3'd0, 8'h10)); put(2, mk(4'b0011, 3'd0, 8'h12)); put(4, mk(4'b0111, 3'd0, 8'h14));
        #1 chk(in_ready == 5'b00001, "R4", in_ready, 5'b00001);
        @(negedge clk); f = ofl(0);
        chk(f[7:0] == 8'h10, "R4", f[7:0], 8'h10);
        in_valid[0] = 1'b0;
        #1 chk(in_ready == 5'b00100, "R5", in_ready, 5'b00100);
        @(negedge clk); f = ofl(0);
        chk(f[7:0] == 8'h12, "R4", f[7:0], 8'h12);
        in_valid[2] = 1'b0;
        #1 chk(in_ready == 5'b10000, "R5", in_ready, 5'b10000);
        @(negedge clk); f = ofl(0);
        chk(f[7:0] == 8'h14, "R4", f[7:0], 8'h14);
        in_valid = '0;

        // R6/R5: stalled output holds while a second packet waits
        @(negedge clk); out_ready = 5'b11110; put(0, mk(4'b0001, 3'd0, 8'ha1));
        @(negedge clk); in_valid = '0; put(2, mk(4'b0011, 3'd1, 8'hb2));
        #1 chk(in_ready[2] == 1'b0, "R5", in_ready[2], 0);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk(out_valid[0] && ofl(0) == mk(4'b0001, 3'd1, 8'ha1), "R6", ofl(0), mk(4'b0001, 3'd1, 8'ha1));
        end
        out_ready = '1;
        #1 chk(in_ready[2] == 1'b1, "R5", in_ready[2], 1);
        @(negedge clk); in_valid = '0;
        chk(out_valid[0] && ofl(0) == mk(4'b0011, 3'd2, 8'hb2), "R6", ofl(0), mk(4'b0011, 3'd2, 8'hb2));
        @(negedge clk);

        // R4/R7/R3: random traffic on all inputs against a priority model
        for (int b = 0; b < 6; b++) begin
            @(negedge clk); in_valid = '0;
            @(negedge clk); node_id = 4'($urandom_range(0, 15));
            for (int c = 0; c < 50; c++) begin
                in_valid = 5'($urandom);
                for (int i = 0; i < NP; i++) begin
                    fl_in[i] = mk(4'($urandom), 3'($urandom_range(0, 2)), 8'($urandom));
                    in_flit[i*FW +: FW] = fl_in[i];
                end
                #1;
                exp_rdy = '0; exp_v = '0;
                for (int o = 0; o < NP; o++) begin
                    exp_f[o] = '0;
                    for (int i = 0; i < NP; i++) begin
                        if (in_valid[i] && !exp_v[o] && exp_port(node_id, fl_in[i][FW-1 -: 4]) == o) begin
                            exp_v[o] = 1'b1; exp_rdy[i] = 1'b1; exp_f[o] = fl_in[i];
                            if (o < DIM) exp_f[o][10:8] = fl_in[i][10:8] + 3'd1;
                        end
                    end
                end
                chk(in_ready == exp_rdy, "R4", in_ready, exp_rdy);
                @(negedge clk);
                chk(out_valid == exp_v, "R7", out_valid, exp_v);
                for (int o = 0; o < NP; o++)
                    if (exp_v[o]) chk(ofl(o) == exp_f[o], "R3", ofl(o), exp_f[o]);
            end
        end
        @(negedge clk); in_valid = '0;
        @(negedge clk);

        // R9: end-to-end walks, directed corners then random pairs
        walk(4'b0000, 4'b1111, 8'h01);
        walk(4'b0101, 4'b1011, 8'h02);
        walk(4'b0110, 4'b0110, 8'h03);
        for (int w = 0; w < 200; w++)
            walk(4'($urandom), 4'($urandom), 8'($urandom));

        finish_run();
    end
endmodule